// File: doc/BRIEF.md
# Privileged Auxiliary Control Register

This block is the auxiliary control register of a processor's system-control coprocessor. It watches the coprocessor transfer bus and responds only to accesses whose opcode and register-number fields select it. Privileged reads return the register contents one cycle later with a strobe. Privileged writes update the seven defined control bits. Any access from user mode that selects the register is refused: it raises a one-cycle undefined-instruction pulse and does not change any state.

The stored bits are not used directly. The block combines them with two bits of the main control register, which arrive as plain inputs: the program-flow-prediction enable and the random-cache-replacement select. From these it produces effective enables for the return stack and for the dynamic and static branch predictors, the MicroTLB replacement choice, and a cache-size limit. It also screens incoming cache-maintenance requests. A request whose class has been disabled in the register raises the same undefined-instruction pulse.

Top module: `aux_ctrl_reg`

## Requirements
- R1: An access is decoded as addressed to this register only when opc1 = 0, crn = 1, crm = 0 and opc2 = 1. Any other access produces no read strobe, no undefined pulse and no change of state.
- R2: After reset the stored bits are 0x00000007. Bits 0 to 2 are 1 and bits 3 to 6 are 0.
- R3: A privileged write loads data bits [6:0]. Bits [31:7] always read as zero, whatever was written.
- R4: A privileged read sets `rd_valid` high for exactly one cycle, in the cycle after the request, with `rd_data` holding the register value as it stood at the request.
- R5: A selected access with `priv_mode` low raises `undef_exc` in the same cycle. It leaves the register unchanged and produces no read strobe.
- R6: Bit 0 (return stack), bit 1 (dynamic prediction) and bit 2 (static prediction) each reach their output only ANDed with `ctl_flow_pred`.
- R7: `utlb_random` is high only when bit 3 and `ctl_rand_repl` are both high. Otherwise the MicroTLB policy is round robin.
- R8: A maintenance request with `cmo_kind` = 1 (block transfer) raises `undef_exc` in the same cycle when bit 5 is set, and raises nothing when bit 5 is clear.
- R9: A maintenance request with `cmo_kind` = 2 (clean entire data cache) or 3 (clean and invalidate entire data cache) raises `undef_exc` in the same cycle when bit 4 is set. A request with `cmo_kind` = 0 (any other operation) never raises it.
- R10: `cache_limit_16k` follows bit 6 and changes only after a privileged write to the register.
- R11: `undef_exc` is low in any cycle with neither a coprocessor access nor a maintenance request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_valid | input | 1 | Coprocessor access present this cycle |
| cp_write | input | 1 | 1 = write, 0 = read |
| cp_opc1 | input | 3 | First opcode field |
| cp_crn | input | 4 | Primary register number |
| cp_crm | input | 4 | Secondary register number |
| cp_opc2 | input | 3 | Second opcode field |
| cp_wdata | input | 32 | Write data |
| priv_mode | input | 1 | 1 = privileged, 0 = user |
| ctl_flow_pred | input | 1 | Program-flow-prediction enable from the main control register |
| ctl_rand_repl | input | 1 | Random cache replacement select from the main control register |
| cmo_valid | input | 1 | Cache-maintenance request present |
| cmo_kind | input | 2 | 0 other, 1 block transfer, 2 clean entire D, 3 clean+invalidate entire D |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data strobe |
| en_ret_stack | output | 1 | Effective return stack enable |
| en_dyn_pred | output | 1 | Effective dynamic prediction enable |
| en_stat_pred | output | 1 | Effective static prediction enable |
| utlb_random | output | 1 | 1 = random MicroTLB replacement, 0 = round robin |
| cache_limit_16k | output | 1 | Restrict cache to 16KB |
| undef_exc | output | 1 | Undefined-instruction pulse |

## Verification
The assertions assume that `priv_mode`, the field inputs and `cmo_kind` hold their values through each clock edge. They also assume that no access is presented while reset is asserted, because the write-gated properties look back one cycle. The bench drives every input on the falling edge, holds all inputs idle during reset, and changes the two main-control bits freely, because the assertions treat them as asynchronous qualifiers. Random accesses are biased toward the selecting field values so that both privilege levels hit the register often, and maintenance requests overlap with those accesses.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int DATA_W = 32;
  localparam int DEF_W  = 7;

  localparam int B_RSTK  = 0;
  localparam int B_DYN   = 1;
  localparam int B_STAT  = 2;
  localparam int B_UTLB  = 3;
  localparam int B_NOCLN = 4;
  localparam int B_NOBLK = 5;
  localparam int B_LIM   = 6;

  localparam logic [DEF_W-1:0] RST_BITS = 7'b000_0111;

  typedef enum logic [1:0] {
    CMO_OTHER  = 2'd0,
    CMO_BLOCK  = 2'd1,
    CMO_CLEAN  = 2'd2,
    CMO_CLNINV = 2'd3
  } cmo_kind_e;

  typedef struct packed {
    logic rd_ok;
    logic wr_ok;
    logic user_hit;
  } acc_s;
endpackage

// File: rtl/acr_decode.sv
module acr_decode #(
  parameter int OPC_W = 3,
  parameter int CR_W  = 4,
  parameter logic [OPC_W-1:0] SEL_OPC1 = 3'd0,
  parameter logic [CR_W-1:0]  SEL_CRN  = 4'd1,
  parameter logic [CR_W-1:0]  SEL_CRM  = 4'd0,
  parameter logic [OPC_W-1:0] SEL_OPC2 = 3'd1
) (
  input  logic             cp_valid,
  input  logic             cp_write,
  input  logic [OPC_W-1:0] cp_opc1,
  input  logic [CR_W-1:0]  cp_crn,
  input  logic [CR_W-1:0]  cp_crm,
  input  logic [OPC_W-1:0] cp_opc2,
  input  logic             priv_mode,
  output acr_pkg::acc_s    acc
);
  logic sel;

  always_comb begin
    sel = cp_valid && (cp_opc1 == SEL_OPC1) && (cp_crn == SEL_CRN)
          && (cp_crm == SEL_CRM) && (cp_opc2 == SEL_OPC2);
    acc.rd_ok    = sel && priv_mode && !cp_write;
    acc.wr_ok    = sel && priv_mode && cp_write;
    acc.user_hit = sel && !priv_mode;
  end
endmodule

// File: rtl/acr_store.sv
module acr_store
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic [DEF_W-1:0]  wbits,
  output logic [DEF_W-1:0]  bits_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int RSV_W = DATA_W - DEF_W;

  logic [DEF_W-1:0]  bits_d;
  logic [DATA_W-1:0] rdat_d;
  logic              rdat_en;

  always_comb begin
    bits_d  = wr_ok ? wbits : bits_q;
    rdat_en = rd_ok;
    rdat_d  = {{RSV_W{1'b0}}, bits_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q   <= RST_BITS;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      bits_q   <= bits_d;
      rd_valid <= rd_ok;
      if (rdat_en) rd_data <= rdat_d;
    end
  end
endmodule

// File: rtl/acr_gate.sv
module acr_gate
  import acr_pkg::*;
(
  input  logic [DEF_W-1:0] bits_q,
  input  logic             ctl_flow_pred,
  input  logic             ctl_rand_repl,
  input  logic             cmo_valid,
  input  logic [1:0]       cmo_kind,
  input  logic             user_hit,
  output logic             en_ret_stack,
  output logic             en_dyn_pred,
  output logic             en_stat_pred,
  output logic             utlb_random,
  output logic             cache_limit_16k,
  output logic             undef_exc
);
  logic cmo_refused;

  always_comb begin
    en_ret_stack    = bits_q[B_RSTK] & ctl_flow_pred;
    en_dyn_pred     = bits_q[B_DYN]  & ctl_flow_pred;
    en_stat_pred    = bits_q[B_STAT] & ctl_flow_pred;
    utlb_random     = bits_q[B_UTLB] & ctl_rand_repl;
    cache_limit_16k = bits_q[B_LIM];
    unique case (cmo_kind_e'(cmo_kind))
      CMO_BLOCK:             cmo_refused = bits_q[B_NOBLK];
      CMO_CLEAN, CMO_CLNINV: cmo_refused = bits_q[B_NOCLN];
      default:               cmo_refused = 1'b0;
    endcase
    undef_exc = user_hit | (cmo_valid & cmo_refused);
  end
endmodule

// File: rtl/aux_ctrl_reg.sv
module aux_ctrl_reg
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_valid,
  input  logic              cp_write,
  input  logic [2:0]        cp_opc1,
  input  logic [3:0]        cp_crn,
  input  logic [3:0]        cp_crm,
  input  logic [2:0]        cp_opc2,
  input  logic [31:0]       cp_wdata,
  input  logic              priv_mode,
  input  logic              ctl_flow_pred,
  input  logic              ctl_rand_repl,
  input  logic              cmo_valid,
  input  logic [1:0]        cmo_kind,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              en_ret_stack,
  output logic              en_dyn_pred,
  output logic              en_stat_pred,
  output logic              utlb_random,
  output logic              cache_limit_16k,
  output logic              undef_exc
);
  acc_s             acc;
  logic [DEF_W-1:0] bits_q;

  acr_decode u_dec (
    .cp_valid (cp_valid),
    .cp_write (cp_write),
    .cp_opc1  (cp_opc1),
    .cp_crn   (cp_crn),
    .cp_crm   (cp_crm),
    .cp_opc2  (cp_opc2),
    .priv_mode(priv_mode),
    .acc      (acc)
  );

  acr_store u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ok   (acc.wr_ok),
    .rd_ok   (acc.rd_ok),
    .wbits   (cp_wdata[DEF_W-1:0]),
    .bits_q  (bits_q),
    .rd_data (rd_data),
    .rd_valid(rd_valid)
  );

  acr_gate u_gate (
    .bits_q         (bits_q),
    .ctl_flow_pred  (ctl_flow_pred),
    .ctl_rand_repl  (ctl_rand_repl),
    .cmo_valid      (cmo_valid),
    .cmo_kind       (cmo_kind),
    .user_hit       (acc.user_hit),
    .en_ret_stack   (en_ret_stack),
    .en_dyn_pred    (en_dyn_pred),
    .en_stat_pred   (en_stat_pred),
    .utlb_random    (utlb_random),
    .cache_limit_16k(cache_limit_16k),
    .undef_exc      (undef_exc)
  );
endmodule

// File: rtl/aux_ctrl_reg_chk.sv
module aux_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cp_valid,
  input logic        cp_write,
  input logic [2:0]  cp_opc1,
  input logic [3:0]  cp_crn,
  input logic [3:0]  cp_crm,
  input logic [2:0]  cp_opc2,
  input logic        priv_mode,
  input logic        ctl_flow_pred,
  input logic        ctl_rand_repl,
  input logic        cmo_valid,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        en_ret_stack,
  input logic        en_dyn_pred,
  input logic        en_stat_pred,
  input logic        utlb_random,
  input logic        cache_limit_16k,
  input logic        undef_exc
);
  logic hit;
  assign hit = cp_valid && cp_opc1 == 3'd0 && cp_crn == 4'd1
               && cp_crm == 4'd0 && cp_opc2 == 3'd1;

  assert_miss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !hit) |=> !rd_valid);

  assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_data[31:7] == 25'd0);

  assert_read_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && priv_mode && !cp_write) |=> rd_valid);

  assert_user_undef_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !priv_mode) |-> undef_exc);

  assert_user_noread_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_valid && !priv_mode) |=> !rd_valid);

  assert_pred_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_flow_pred |-> !(en_ret_stack || en_dyn_pred || en_stat_pred));

  assert_utlb_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rand_repl |-> !utlb_random);

  assert_limit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && priv_mode && cp_write) |=> $stable(cache_limit_16k));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cp_valid && !cmo_valid) |-> !undef_exc);
endmodule

bind aux_ctrl_reg aux_ctrl_reg_chk u_chk (.*);

// File: tb/test_aux_ctrl_reg.sv
module test_aux_ctrl_reg;
  logic        clk, rst_n;
  logic        cp_valid, cp_write, priv_mode;
  logic [2:0]  cp_opc1, cp_opc2;
  logic [3:0]  cp_crn, cp_crm;
  logic [31:0] cp_wdata;
  logic        ctl_flow_pred, ctl_rand_repl, cmo_valid;
  logic [1:0]  cmo_kind;
  logic [31:0] rd_data;
  logic        rd_valid, en_ret_stack, en_dyn_pred, en_stat_pred;
  logic        utlb_random, cache_limit_16k, undef_exc;

  int n_run, n_fail;
  bit done;

  aux_ctrl_reg i_aux_ctrl_reg (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference
  logic [6:0]  m_bits;
  logic [31:0] m_rdata;
  logic        m_rvalid;

  function automatic bit sel_now();
    return cp_valid && cp_opc1 == 0 && cp_crn == 1 && cp_crm == 0 && cp_opc2 == 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_bits <= 7'h07; m_rdata <= 0; m_rvalid <= 0;
    end else begin
      m_rvalid <= sel_now() && priv_mode && !cp_write;
      if (sel_now() && priv_mode && !cp_write) m_rdata <= {25'd0, m_bits};
      if (sel_now() && priv_mode && cp_write) m_bits <= cp_wdata[6:0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit eu; string tg;
    eu = sel_now() && !priv_mode;
    tg = eu ? "R5" : "R11";
    if (cmo_valid && cmo_kind == 1) begin
      eu = eu || m_bits[5]; tg = "R8";
    end
    if (cmo_valid && cmo_kind >= 2) begin
      eu = eu || m_bits[4]; tg = "R9";
    end
    chk(tg, {31'd0, undef_exc}, {31'd0, eu});
    chk("R4", {31'd0, rd_valid}, {31'd0, m_rvalid});
    if (m_rvalid) chk("R4", rd_data, m_rdata);
    chk("R6", {29'd0, en_ret_stack, en_dyn_pred, en_stat_pred},
        {29'd0, m_bits[0] & ctl_flow_pred, m_bits[1] & ctl_flow_pred, m_bits[2] & ctl_flow_pred});
    chk("R7", {31'd0, utlb_random}, {31'd0, m_bits[3] & ctl_rand_repl});
    chk("R10", {31'd0, cache_limit_16k}, {31'd0, m_bits[6]});
  endtask

  task automatic drive(input bit v, input bit w, input bit p, input bit hitf,
                       input logic [31:0] d, input bit cv, input logic [1:0] ck);
    @(negedge clk);
    cp_valid = v; cp_write = w; priv_mode = p; cp_wdata = d;
    cp_opc1 = hitf ? 3'd0 : 3'd0; cp_crn = 4'd1; cp_crm = 4'd0;
    cp_opc2 = hitf ? 3'd1 : 3'd2;
    cmo_valid = cv; cmo_kind = ck;
    #1 compare_all();
  endtask

  task automatic idle();
    drive(0, 0, 1, 1, 32'h0, 0, 2'd0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 0; cp_valid = 0; cp_write = 0; priv_mode = 1; cp_wdata = 0;
    cp_opc1 = 0; cp_crn = 0; cp_crm = 0; cp_opc2 = 0;
    ctl_flow_pred = 1; ctl_rand_repl = 1; cmo_valid = 0; cmo_kind = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R2", {25'd0, en_stat_pred, en_dyn_pred, en_ret_stack, utlb_random, 3'd0},
           {25'd0, 3'b111, 1'b0, 3'd0});
    // R2 reset value read back
    drive(1, 0, 1, 1, 0, 0, 0); idle();
    chk("R2", rd_data, 32'h0000_0007);
    // R3 reserved bits ignored
    drive(1, 1, 1, 1, 32'hFFFF_FFFF, 0, 0);
    drive(1, 0, 1, 1, 0, 0, 0); idle();
    chk("R3", rd_data, 32'h0000_007F);
    // R8 / R9 refused with bits 4,5 set
    drive(0, 0, 1, 1, 0, 1, 2'd1); chk("R8", {31'd0, undef_exc}, 32'd1);
    drive(0, 0, 1, 1, 0, 1, 2'd3); chk("R9", {31'd0, undef_exc}, 32'd1);
    drive(0, 0, 1, 1, 0, 1, 2'd0); chk("R9", {31'd0, undef_exc}, 32'd0);
    // R5 user write ignored
    drive(1, 1, 0, 1, 32'h0, 0, 0); chk("R5", {31'd0, undef_exc}, 32'd1);
    drive(1, 0, 1, 1, 0, 0, 0); idle();
    chk("R5", rd_data, 32'h0000_007F);
    // R1 miss write ignored
    drive(1, 1, 1, 0, 32'h0, 0, 0); chk("R1", {31'd0, undef_exc}, 32'd0);
    drive(1, 0, 1, 1, 0, 0, 0); idle();
    chk("R1", rd_data, 32'h0000_007F);
    // R8 allowed when clear
    drive(1, 1, 1, 1, 32'h0, 0, 0);
    drive(0, 0, 1, 1, 0, 1, 2'd1); chk("R8", {31'd0, undef_exc}, 32'd0);
    drive(0, 0, 1, 1, 0, 1, 2'd2); chk("R9", {31'd0, undef_exc}, 32'd0);
    // random traffic, reference compared every cycle
    for (int i = 0; i < 3000; i++) begin
      ctl_flow_pred = $urandom_range(0, 1);
      ctl_rand_repl = $urandom_range(0, 1);
      drive($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3) != 0,
            $urandom_range(0, 4) != 0, $urandom, $urandom_range(0, 1),
            2'($urandom_range(0, 3)));
    end
    idle(); idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule